// File: doc/BRIEF.md
# Serial Transmitter with Occupancy Watermark

This block is a memory-mapped serial transmitter. Software writes characters through a word-addressed register bus. Each character goes into an eight-entry queue. A frame engine drains the queue onto a single serial line, one frame per character. A programmable divisor sets the bit time.

Software polls a full indication before each write. To learn when the line has drained, it programs an occupancy watermark. A pending flag is raised while the queue holds fewer characters than the watermark, so a watermark of one means "queue empty". The pending flag is gated by an enable bit to form a level interrupt.

The register words sit at word indices 0 to 6 (byte offsets 0x00 to 0x18). The order is: character data, a receive data word, transmit control, a receive control word, interrupt enable, interrupt pending, divisor. The receive words read as zero and ignore writes, since reception is outside this block.

Top module: `uart_tx_wm`

## Requirements
- R1: After reset the line output is 1, the interrupt is 0, and transmit control, interrupt enable, interrupt pending and divisor (word indices 2, 4, 5, 6) all read 0.
- R2: A write to word index 0 queues bits 7:0 as one character. Characters leave in write order, and the queue holds up to 8 of them.
- R3: A read of word index 0 returns 1 in bit 31 exactly when 8 characters are queued. A write to word index 0 while the queue is full is dropped and never transmitted.
- R4: Each frame is one low start bit, then the 8 data bits least significant first, then high stop bits. The line is high whenever no frame is in progress.
- R5: Transmit control bit 1 holds the stop-bit count minus one: 0 gives one stop bit and 1 gives two.
- R6: Every bit of a frame lasts divisor + 1 clock cycles. The divisor is the low bits of word index 6.
- R7: Transmit control bit 0 enables transmission. While it is 0, no new frame starts and the queued characters are kept until it is set again.
- R8: Transmit control bits 18:16 hold a watermark W. Interrupt pending bit 0 (word index 5) reads 1 exactly when the queue holds fewer than W characters. Writes to word index 5 have no effect.
- R9: The interrupt output equals interrupt pending bit 0 ANDed with interrupt enable bit 0 (word index 4).
- R10: When a character is queued at the end of a frame, the next start bit directly follows the last stop bit, with no extra idle time.
- R11: A character write accepted in the same cycle that a frame takes a character from the queue leaves the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Word index of the register accessed |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| tx_o | output | 1 | Serial line output, idle high |
| irq_o | output | 1 | Level interrupt |

## Verification
Two things can happen in the same cycle: a software write adding a character, and the frame engine taking a character out. The bench provokes this with the watermark set to 7 and seven characters queued while transmission is disabled. It then enables transmission and, in the very next cycle, the cycle in which the first frame starts, writes an eighth character. A correct queue stays at seven, so the pending flag must read 0; a queue that lost or double-counted an entry shows 1. All eight characters must then come out in order.

// File: rtl/uart_tx_wm.sv
module uart_tx_wm #(
  parameter int DEPTH = 8,
  parameter int DIV_W = 16,
  parameter int WM_W  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        tx_o,
  output logic        irq_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic             en_q, nstop_q, ie_q;
  logic [WM_W-1:0]  wm_q;
  logic [DIV_W-1:0] div_q, baud_q;
  logic [7:0]       mem [DEPTH];
  logic [PW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    cnt_q;
  logic             busy_q;
  logic [10:0]      sh_q;
  logic [3:0]       bits_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  logic wr_data, wr_ctrl, wr_ie, wr_div;
  assign wr_data = bus_wr && bus_addr == 3'd0;
  assign wr_ctrl = bus_wr && bus_addr == 3'd2;
  assign wr_ie   = bus_wr && bus_addr == 3'd4;
  assign wr_div  = bus_wr && bus_addr == 3'd6;

  logic full, push, tick, last, pop, wm_flag;
  assign full    = cnt_q == CW'(DEPTH);
  assign push    = wr_data && !full;
  assign tick    = busy_q && baud_q == div_q;
  assign last    = tick && bits_q == 4'd0;
  assign pop     = en_q && cnt_q != '0 && (!busy_q || last);
  assign wm_flag = int'(cnt_q) < int'(wm_q);

  assign tx_o  = busy_q ? sh_q[0] : 1'b1;
  assign irq_o = wm_flag & ie_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      3'd0: bus_rdata[31] = full;
      3'd2: begin
        bus_rdata[0]         = en_q;
        bus_rdata[1]         = nstop_q;
        bus_rdata[16 +: WM_W] = wm_q;
      end
      3'd4: bus_rdata[0] = ie_q;
      3'd5: bus_rdata[0] = wm_flag;
      3'd6: bus_rdata[DIV_W-1:0] = div_q;
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk)
    if (push) mem[wp_q] <= bus_wdata[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      nstop_q <= 1'b0;
      wm_q    <= '0;
      ie_q    <= 1'b0;
      div_q   <= '0;
      wp_q    <= '0;
      rp_q    <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      sh_q    <= '1;
      bits_q  <= '0;
      baud_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q    <= bus_wdata[0];
        nstop_q <= bus_wdata[1];
        wm_q    <= bus_wdata[16 +: WM_W];
      end
      if (wr_ie)  ie_q  <= bus_wdata[0];
      if (wr_div) div_q <= bus_wdata[DIV_W-1:0];
      if (push) wp_q <= nxt(wp_q);
      if (pop)  rp_q <= nxt(rp_q);
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
      if (pop) begin
        busy_q <= 1'b1;
        sh_q   <= {2'b11, mem[rp_q], 1'b0};
        bits_q <= nstop_q ? 4'd10 : 4'd9;
        baud_q <= '0;
      end else if (last) begin
        busy_q <= 1'b0;
      end else if (tick) begin
        sh_q   <= {1'b1, sh_q[10:1]};
        bits_q <= bits_q - 4'd1;
        baud_q <= '0;
      end else if (busy_q) begin
        baud_q <= baud_q + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/uart_tx_wm_chk.sv
module uart_tx_wm_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cnt,
  input logic          busy,
  input logic          en,
  input logic          tx,
  input logic          push,
  input logic          pop,
  input logic          wr,
  input logic [2:0]    addr
);
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= DEPTH);

  a_r11_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> cnt == $past(cnt));

  a_r4_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx);

  a_r7_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(en));

  a_r3_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 3'd0 && int'(cnt) == DEPTH && !pop) |=> int'(cnt) == DEPTH);
endmodule

bind uart_tx_wm uart_tx_wm_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .busy(busy_q), .en(en_q),
  .tx(tx_o), .push(push), .pop(pop), .wr(bus_wr), .addr(bus_addr)
);

// File: tb/test_uart_tx_wm.sv
`timescale 1ns/1ps
module test_uart_tx_wm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tx, irq;
  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  uart_tx_wm i_uart_tx_wm (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rdata(rdata), .tx_o(tx), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic brd(input logic [2:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic wait_low(output bit ok);
    int w = 0;
    while (tx !== 1'b0 && w < 3000) begin @(negedge clk); w++; end
    ok = (w < 3000);
  endtask

  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (tx === lvl && n < 3000) begin n++; @(negedge clk); end
  endtask

  task automatic get_frame(input int t, input int ns, output logic [7:0] b, output bit ok);
    b = '0;
    wait_low(ok);
    if (!ok) return;
    repeat (t / 2) @(negedge clk);
    if (tx !== 1'b0) ok = 1'b0;
    for (int i = 0; i < 8; i++) begin
      repeat (t) @(negedge clk);
      b[i] = tx;
    end
    for (int i = 0; i < ns; i++) begin
      repeat (t) @(negedge clk);
      if (tx !== 1'b1) ok = 1'b0;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk(tx === 1'b1, "R1 idle line", tx, 1);
    chk(irq === 1'b0, "R1 irq", irq, 0);
    brd(3'd2, v); chk(v == 0, "R1 ctrl", v, 0);
    brd(3'd4, v); chk(v == 0, "R1 ie", v, 0);
    brd(3'd5, v); chk(v == 0, "R1 ip", v, 0);
    brd(3'd6, v); chk(v == 0, "R1 div", v, 0);
    brd(3'd0, v); chk(v[31] == 1'b0, "R3 not full", v[31], 0);
  endtask

  task automatic t_frame(input int d);
    int n; bit ok; logic [7:0] b;
    bwr(3'd6, d);
    bwr(3'd2, 32'h1);
    bwr(3'd0, 32'h0000_0100);
    wait_low(ok);
    run_len(1'b0, n);
    chk(ok && n == 9 * (d + 1), "R6 bit time", n, 9 * (d + 1));
    bwr(3'd0, 32'hFFFF_FFA5);
    get_frame(d + 1, 1, b, ok);
    chk(ok && b == 8'hA5, "R4 R2 frame A5", b, 8'hA5);
  endtask

  task automatic t_stops(input int ns);
    int l1, h, l2; bit ok;
    bwr(3'd6, 32'd3);
    bwr(3'd2, (ns == 2) ? 32'h3 : 32'h1);
    bwr(3'd0, 32'h0);
    bwr(3'd0, 32'h0);
    wait_low(ok);
    run_len(1'b0, l1);
    run_len(1'b1, h);
    run_len(1'b0, l2);
    chk(ok && l1 == 36 && l2 == 36, "R4 zero frames", l2, 36);
    chk(h == 4 * ns, "R5 R10 stop gap", h, 4 * ns);
    repeat (12) @(negedge clk);
  endtask

  task automatic t_wm;
    logic [31:0] v; bit ok; logic [7:0] b;
    bwr(3'd2, 32'h0004_0000);
    for (int i = 0; i < 3; i++) bwr(3'd0, 32'h50 + i);
    brd(3'd5, v); chk(v[0] == 1'b1, "R8 below wm", v[0], 1);
    bwr(3'd4, 32'h1);
    chk(irq === 1'b1, "R9 irq on", irq, 1);
    bwr(3'd5, 32'h0);
    brd(3'd5, v); chk(v[0] == 1'b1, "R8 ip read-only", v[0], 1);
    bwr(3'd0, 32'h53);
    brd(3'd5, v); chk(v[0] == 1'b0, "R8 at wm", v[0], 0);
    chk(irq === 1'b0, "R9 irq off", irq, 0);
    bwr(3'd4, 32'h0);
    bwr(3'd2, 32'h0004_0001);
    for (int i = 0; i < 4; i++) begin
      get_frame(4, 1, b, ok);
      chk(ok && b == 8'h50 + i, "R2 wm flush order", b, 8'h50 + i);
    end
    brd(3'd5, v); chk(v[0] == 1'b1, "R8 empty", v[0], 1);
    chk(irq === 1'b0, "R9 masked", irq, 0);
  endtask

  task automatic t_full;
    logic [31:0] v; bit ok; bit idle; logic [7:0] b;
    bwr(3'd2, 32'h0001_0000);
    for (int i = 0; i < 8; i++) bwr(3'd0, 32'h31 + i);
    brd(3'd0, v); chk(v[31] == 1'b1, "R3 full flag", v[31], 1);
    bwr(3'd0, 32'h99);
    idle = 1'b1;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (tx !== 1'b1) idle = 1'b0; end
    chk(idle, "R7 disabled no frame", idle, 1);
    brd(3'd5, v); chk(v[0] == 1'b0, "R7 queue kept", v[0], 0);
    bwr(3'd2, 32'h0001_0001);
    for (int i = 0; i < 8; i++) begin
      get_frame(4, 1, b, ok);
      chk(ok && b == 8'h31 + i, "R2 R7 order", b, 8'h31 + i);
    end
    idle = 1'b1;
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (tx !== 1'b1) idle = 1'b0; end
    chk(idle, "R3 dropped write", idle, 1);
  endtask

  task automatic t_same;
    logic [31:0] v; bit ok; logic [7:0] b;
    bwr(3'd2, 32'h0007_0000);
    for (int i = 0; i < 7; i++) bwr(3'd0, 32'h10 + i);
    brd(3'd5, v); chk(v[0] == 1'b0, "R8 seven vs wm 7", v[0], 0);
    bwr(3'd2, 32'h0007_0001);
    bwr(3'd0, 32'h17);
    brd(3'd5, v); chk(v[0] == 1'b0, "R11 push with pop", v[0], 0);
    for (int i = 0; i < 8; i++) begin
      get_frame(4, 1, b, ok);
      chk(ok && b == 8'h10 + i, "R11 order", b, 8'h10 + i);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_frame(1);
    t_frame(3);
    t_stops(1);
    t_stops(2);
    t_wm();
    t_full();
    t_same();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule